// File: doc/BRIEF.md
# Read-once device secret store

This block holds a 256-bit per-device secret and hands it to boot firmware over a small word bus. The secret is split into eight 32-bit words. Each word can be read once after reset. The read sets a sticky flag for that word, and every later read of it is refused. Once the external mode controller raises the application-mode input, every secret read is refused, whatever the state of the flags. No bus access can change the secret. The block also answers three fixed identification reads, so software can check what sits at this address range.

A requester drives `bus_req` for one cycle with an address, a size code and a write flag. The answer comes on the next cycle. On that cycle `bus_rdata` carries the data and `bus_err` pulses high for one cycle if the access was refused. A refused access always reads back as zero. The secret value is a parameter that is fixed at reset.

Top module: `secret_store`

## Requirements
- R1: After reset, `bus_rdata` is 0 and `bus_err` is 0.
- R2: A 4-byte read (size code 2) at offset SECRET_BASE+4*i (default 0x40..0x5c) returns secret word i, which is bits [32*i+31:32*i] of SECRET_VALUE. The data and `bus_err`=0 appear in the cycle after the request. The first such read of word i is accepted in any order.
- R3: Any later read of a word that has already been read returns 0 with `bus_err`=1. Words not yet read stay readable.
- R4: While `app_mode` is 1, every secret read returns 0 with `bus_err`=1 and does not mark the word as read.
- R5: A write (`bus_we`=1) to any offset is refused with `bus_err`=1 and `bus_rdata`=0. It leaves the secret and the read flags unchanged.
- R6: An access with a size code other than 2, or with address bits [1:0] not 00, is refused with `bus_err`=1 and data 0. It does not mark any word as read.
- R7: Reads at offset 0x00, 0x04 and 0x08 return ID_NAME0, ID_NAME1 and ID_VERSION with `bus_err`=0. They can be repeated, and `app_mode` has no effect on them.
- R8: A read of any other offset returns 0 with `bus_err`=1.
- R9: The read flags are cleared only by reset. After a reset every secret word can be read once again.
- R10: `bus_err` is high only in the cycle that follows a request, and `bus_rdata` is 0 in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_mode | input | 1 | 1 once the system has left firmware mode |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data (always refused) |
| bus_rdata | output | 32 | Read data, valid in the cycle after the request |
| bus_err | output | 1 | One-cycle refusal strobe, in the cycle after the request |

## Verification
The hardest state to reach is the one that shows a refused access did not consume a word. Refused reads and plain accepted reads look the same on the ports until the word is read again. The stimulus therefore sends refused reads to one word: in app mode, with a bad size, misaligned, and as a write. It then drops app mode and reads that word, which must still return its value, and reads it a second time, which must fail. A mid-test reset is then applied, and all eight words are read again to show that only reset clears the flags.

// File: rtl/secret_store_pkg.sv
package secret_store_pkg;

    localparam int unsigned WORD_W = 32;

    // Size code 2 is the only legal access size (4 bytes).
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_IDENT  = 2'd1,
        REG_SECRET = 2'd2
    } region_e;

    typedef struct packed {
        region_e    region;
        logic       shape_ok;
        logic [1:0] id_sel;
    } decode_t;

    function automatic logic access_shape_ok(input logic [1:0] size, input logic [1:0] lo);
        return (size == SIZE_WORD) && (lo == 2'b00);
    endfunction

endpackage

// File: rtl/ss_decode.sv
module ss_decode
    import secret_store_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned SECRET_WORDS = 8,
    parameter logic [ADDR_W-1:0] SECRET_BASE = 'h40,
    localparam int unsigned IDX_W = (SECRET_WORDS > 1) ? $clog2(SECRET_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output decode_t           dec,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(SECRET_WORDS * 4);

    logic [ADDR_W-1:0] rel;
    logic              in_secret;

    always_comb begin
        rel       = addr - SECRET_BASE;
        in_secret = (addr >= SECRET_BASE) && ({1'b0, rel} < SPAN);
        idx       = rel[IDX_W+1:2];

        dec.shape_ok = access_shape_ok(size, addr[1:0]);
        dec.id_sel   = 2'd0;
        dec.region   = REG_NONE;
        if (in_secret) begin
            dec.region = REG_SECRET;
        end else if (addr[ADDR_W-1:4] == '0 && addr[3:2] != 2'b11) begin
            dec.region = REG_IDENT;
            dec.id_sel = addr[3:2];
        end
    end

endmodule

// File: rtl/ss_guard.sv
module ss_guard #(
    parameter int unsigned SECRET_WORDS = 8,
    localparam int unsigned IDX_W = (SECRET_WORDS > 1) ? $clog2(SECRET_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_secret,
    input  logic [IDX_W-1:0] idx,
    input  logic             app_mode,
    output logic             grant
);
    logic [SECRET_WORDS-1:0] blocked;
    logic [SECRET_WORDS-1:0] set_vec;

    assign grant = rd_secret && !app_mode && !blocked[idx];

    for (genvar w = 0; w < SECRET_WORDS; w++) begin : g_flag
        assign set_vec[w] = grant && (idx == IDX_W'(w));
        always_ff @(posedge clk) begin
            if (rst) blocked[w] <= 1'b0;
            else     blocked[w] <= blocked[w] | set_vec[w];
        end
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(blocked) & ~blocked) == '0)); // R9
    AST_APP_NO_CONSUME: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> $stable(blocked)); // R4
    AST_ONE_WORD_PER_READ: assert property (@(posedge clk) disable iff (rst)
        $countones(blocked ^ $past(blocked)) <= 1); // R2
    AST_BLOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (rd_secret && blocked[idx]) |-> !grant); // R3

endmodule

// File: rtl/ss_resp.sv
module ss_resp
    import secret_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              accept,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] rdata,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= (req && accept) ? data : '0;
            err   <= req && !accept;
        end
    end

endmodule

// File: rtl/secret_store.sv
module secret_store
    import secret_store_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned SECRET_WORDS = 8,
    parameter logic [ADDR_W-1:0] SECRET_BASE = 'h40,
    parameter logic [SECRET_WORDS*32-1:0] SECRET_VALUE =
        256'hf7f7f7f7_e6e6e6e6_d5d5d5d5_c4c4c4c4_b3b3b3b3_a2a2a2a2_91919191_80808080,
    parameter logic [31:0] ID_NAME0   = 32'h7365_6372,
    parameter logic [31:0] ID_NAME1   = 32'h7374_6f72,
    parameter logic [31:0] ID_VERSION = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              app_mode,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);
    localparam int unsigned IDX_W = (SECRET_WORDS > 1) ? $clog2(SECRET_WORDS) : 1;

    decode_t           dec;
    logic [IDX_W-1:0]  idx;
    logic              rd_secret;
    logic              grant;
    logic              accept;
    logic [WORD_W-1:0] data;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    ss_decode #(
        .ADDR_W(ADDR_W), .SECRET_WORDS(SECRET_WORDS), .SECRET_BASE(SECRET_BASE)
    ) u_decode (
        .addr(bus_addr), .size(bus_size), .dec(dec), .idx(idx)
    );

    assign rd_secret = bus_req && !bus_we && dec.shape_ok && (dec.region == REG_SECRET);

    ss_guard #(.SECRET_WORDS(SECRET_WORDS)) u_guard (
        .clk(clk), .rst(rst), .rd_secret(rd_secret), .idx(idx),
        .app_mode(app_mode), .grant(grant)
    );

    always_comb begin
        accept = 1'b0;
        data   = '0;
        if (!bus_we && dec.shape_ok) begin
            unique case (dec.region)
                REG_IDENT: begin
                    accept = 1'b1;
                    case (dec.id_sel)
                        2'd0:    data = ID_NAME0;
                        2'd1:    data = ID_NAME1;
                        default: data = ID_VERSION;
                    endcase
                end
                REG_SECRET: begin
                    accept = grant;
                    data   = SECRET_VALUE[idx*32 +: 32];
                end
                default: accept = 1'b0;
            endcase
        end
    end

    ss_resp u_resp (
        .clk(clk), .rst(rst), .req(bus_req), .accept(accept), .data(data),
        .rdata(bus_rdata), .err(bus_err)
    );

    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rdata == '0)); // R3
    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_req) |-> (!bus_err && bus_rdata == '0)); // R10
    AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> bus_err); // R5
    AST_SHAPE_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (bus_size != SIZE_WORD || bus_addr[1:0] != 2'b00)) |=> bus_err); // R6
    AST_APP_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && app_mode && dec.region == REG_SECRET) |=> bus_err); // R4

endmodule

// File: tb/secret_store_bench.sv
module secret_store_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        app_mode = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    secret_store u_secret_store (
        .clk(clk), .rst(rst), .app_mode(app_mode), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [31:0] exp_word(input int i);
        logic [7:0] b;
        b = 8'h80 + 8'(8'h11 * i);
        return {b, b, b, b};
    endfunction

    task automatic check(input string tag, input logic [31:0] act_d, input logic act_e,
                         input logic [31:0] exp_d, input logic exp_e);
        tests++;
        if (act_d !== exp_d || act_e !== exp_e) begin
            fails++;
            $display("FAIL %s: data=%h err=%0b expected data=%h err=%0b",
                     tag, act_d, act_e, exp_d, exp_e);
        end
    endtask

    // One access; returns the registered response seen one cycle later.
    task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] size,
                          output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = size;
        bus_wdata = 32'hdead_beef;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset state", bus_rdata, bus_err, 32'h0, 1'b0);
    endtask

    task automatic t_first_reads();
        logic [31:0] d; logic e;
        for (int i = 7; i >= 0; i--) begin
            if (i == 3) continue; // word 3 is kept for the refusal scenario
            access(1'b0, 8'h40 + 8'(4*i), 2'd2, d, e);
            check($sformatf("R2 first read word %0d", i), d, e, exp_word(i), 1'b0);
        end
    endtask

    task automatic t_second_reads();
        logic [31:0] d; logic e;
        access(1'b0, 8'h40, 2'd2, d, e);
        check("R3 second read word 0", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h5c, 2'd2, d, e);
        check("R3 second read word 7", d, e, 32'h0, 1'b1);
    endtask

    task automatic t_refusals_keep_word();
        logic [31:0] d; logic e;
        app_mode = 1'b1;
        access(1'b0, 8'h4c, 2'd2, d, e);
        check("R4 app mode read word 3", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h04, 2'd2, d, e);
        check("R7 ident in app mode", d, e, 32'h7374_6f72, 1'b0);
        app_mode = 1'b0;
        access(1'b1, 8'h4c, 2'd2, d, e);
        check("R5 write word 3", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h4c, 2'd1, d, e);
        check("R6 half size word 3", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h4d, 2'd2, d, e);
        check("R6 misaligned word 3", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h4c, 2'd2, d, e);
        check("R4 R5 R6 word 3 still readable", d, e, exp_word(3), 1'b0);
        access(1'b0, 8'h4c, 2'd2, d, e);
        check("R3 word 3 now blocked", d, e, 32'h0, 1'b1);
    endtask

    task automatic t_ident();
        logic [31:0] d; logic e;
        access(1'b0, 8'h00, 2'd2, d, e);
        check("R7 name0", d, e, 32'h7365_6372, 1'b0);
        access(1'b0, 8'h00, 2'd2, d, e);
        check("R7 name0 repeat", d, e, 32'h7365_6372, 1'b0);
        access(1'b0, 8'h08, 2'd2, d, e);
        check("R7 version", d, e, 32'h1, 1'b0);
        access(1'b1, 8'h08, 2'd2, d, e);
        check("R5 write ident", d, e, 32'h0, 1'b1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        access(1'b0, 8'h0c, 2'd2, d, e);
        check("R8 read 0x0c", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h60, 2'd2, d, e);
        check("R8 read 0x60", d, e, 32'h0, 1'b1);
        access(1'b0, 8'h3c, 2'd2, d, e);
        check("R8 read 0x3c", d, e, 32'h0, 1'b1);
    endtask

    task automatic t_idle();
        logic [31:0] d; logic e;
        access(1'b0, 8'h44, 2'd2, d, e); // refused: word 1 already read
        @(negedge clk);
        check("R10 strobe gone after one cycle", bus_rdata, bus_err, 32'h0, 1'b0);
    endtask

    task automatic t_reset_clears();
        logic [31:0] d; logic e;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            access(1'b0, 8'h40 + 8'(4*i), 2'd2, d, e);
            check($sformatf("R9 read word %0d after reset", i), d, e, exp_word(i), 1'b0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_reads();
        t_second_reads();
        t_refusals_keep_word();
        t_ident();
        t_unmapped();
        t_idle();
        t_reset_clears();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++; tests++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule